// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three 16-bit down-counters that run independently of each other. Each has a count-enable strobe (`tick`), a gate input and a timer output. Software sets each counter up through a byte-wide register port. It writes a control word that picks the counter, the byte access format, the operating mode and binary or BCD arithmetic. It then writes the start count. Two periodic modes are provided. The rate generator pulses its output low for one count period at the end of every cycle. The square wave mode toggles its output at every half period.

A counter can be read at any time without stopping it. A direct read returns the running value, so the two bytes of a multi-byte read may come from different counts. A latch command written through the control address freezes a snapshot of the count. That snapshot is returned until the read sequence completes, while the counter itself keeps running.

All logic runs on a single clock. A counter advances on a clock edge only when its `tick` strobe is high and its gate is high.

Top module: `tmr3_top`

## Requirements
- R1: After reset every timer output is high, and each counter reads back 0 using the LSB-then-MSB read format.
- R2: Writes to address 3 are control words. Bits [7:6] select the counter, bits [5:4] the access format (0 latch, 1 LSB only, 2 MSB only, 3 LSB then MSB), bits [3:1] the mode, and bit 0 chooses BCD (1) or binary (0). A selector value of 3 has no effect. Reading address 3 returns 0.
- R3: The count is written at the counter's own address (0 to 2). In the LSB-only format the byte sets bits [7:0] and clears the high byte. In the MSB-only format the byte sets bits [15:8] and clears the low byte. In the LSB-then-MSB format the counter takes the value only after both bytes have arrived. Counting starts when the load completes, and reads use the same format.
- R4: A counter changes only on an edge where its tick is high and its gate is high. A low gate forces the output high. A rising gate reloads the start count.
- R5: Mode code 2 (any code other than 3) is the rate generator. With start count N, the output is low for exactly one tick after every N-th tick and high otherwise.
- R6: In BCD mode every nibble counts 9 down to 0 with a borrow to the next digit. A start count of 0 stands for 10000 in BCD and 65536 in binary, so the first tick gives 9999 or FFFF.
- R7: Mode code 3 is square wave. For an even N the output is high for N/2 ticks, then low for N/2 ticks, repeating.
- R8: In square wave mode with an odd N, the high phase lasts (N+1)/2 ticks and the low phase lasts (N-1)/2 ticks.
- R9: A latch command (format 0) captures the count. That value is returned until the read sequence of the current format completes. Further latch commands for the same counter are ignored until then.
- R10: A read without a latch returns the live count and does not disturb counting.
- R11: A control word with a format other than latch stops its counter, drives its output high and restarts the write and read byte order. Ticks have no effect until a new count is loaded.
- R12: Ticks, gates, loads and reads of one counter leave the other counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 to 2 counters, 3 control |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid in the cycle `rd_en` is high |
| tick | input | 3 | Per-counter count-enable strobe |
| gate | input | 3 | Per-counter gate |
| tmr_out | output | 3 | Per-counter timer output |

## Verification
The hardest case to reach is a latch that overlaps a running counter:
- a second latch command arrives between the two byte reads;
- ticks keep arriving before, between and after those reads.

The bench reaches this by interleaving tick pulses with the latch commands and with the single-byte reads. It then expects the first snapshot on both bytes and the live value afterwards. Odd square-wave counts are also hard to hit, because the first decrement of each phase differs from the rest. The bench checks both phases against a phase-length model. BCD borrow is reached by loading 0 and 12 and reading the count after a few ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // Byte access format carried in the control word
    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } acc_e;

    localparam int CW_SEL_LSB  = 6;
    localparam int CW_ACC_LSB  = 4;
    localparam int CW_MODE_LSB = 1;
    localparam int CW_BCD_BIT  = 0;
    localparam int SEL_W       = 2;
    localparam logic [2:0] MODE_SQUARE = 3'd3;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2,
    parameter int BUS_W  = 8
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [NUM_CH-1:0] cfg_wr,
    output logic [NUM_CH-1:0] latch_cmd,
    output logic [NUM_CH-1:0] data_wr,
    output logic [NUM_CH-1:0] data_rd,
    output acc_e              cfg_acc,
    output logic              cfg_sq,
    output logic              cfg_bcd
);
    logic [SEL_W-1:0] sel;
    logic [2:0]       mode;
    logic             ctrl_hit;

    always_comb begin
        sel       = wdata[CW_SEL_LSB +: SEL_W];
        mode      = wdata[CW_MODE_LSB +: 3];
        cfg_acc   = acc_e'(wdata[CW_ACC_LSB +: 2]);
        cfg_sq    = (mode == MODE_SQUARE);
        cfg_bcd   = wdata[CW_BCD_BIT];
        ctrl_hit  = wr_en && (addr == ADDR_W'(NUM_CH));
        cfg_wr    = '0;
        latch_cmd = '0;
        data_wr   = '0;
        data_rd   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            // R2: selector codes at or above NUM_CH match no channel
            if (ctrl_hit && sel == SEL_W'(i)) begin
                if (cfg_acc == ACC_LATCH) latch_cmd[i] = 1'b1;
                else                      cfg_wr[i]    = 1'b1;
            end
            if (wr_en && addr == ADDR_W'(i)) data_wr[i] = 1'b1;
            if (rd_en && addr == ADDR_W'(i)) data_rd[i] = 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             cfg_wr,
    input  acc_e             cfg_acc,
    input  logic             cfg_sq,
    input  logic             cfg_bcd,
    input  logic             latch_cmd,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             tout
);
    localparam int DIGITS = CNT_W / 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] snap;
        logic [BUS_W-1:0] lo_hold;
        acc_e             acc;
        logic             sq;
        logic             bcd;
        logic             armed;
        logic             held;
        logic             wr_hi;
        logic             rd_hi;
        logic             out;
        logic             gate_q;
    } ch_state_t;

    ch_state_t s_q, s_d;

    // Subtract 1..3 in binary or in packed BCD (R6)
    function automatic logic [CNT_W-1:0] sub_small(input logic [CNT_W-1:0] v,
                                                   input logic [1:0] k,
                                                   input logic bcd_mode);
        logic [CNT_W-1:0] r;
        int b;
        int t;
        r = '0;
        b = int'(k);
        t = 0;
        if (!bcd_mode) begin
            r = v - CNT_W'(k);
        end else begin
            for (int i = 0; i < DIGITS; i++) begin
                t = int'(v[4*i +: 4]) - b;
                if (t < 0) begin
                    t = t + 10;
                    b = 1;
                end else begin
                    b = 0;
                end
                r[4*i +: 4] = 4'(t);
            end
        end
        return r;
    endfunction

    logic [1:0]       step;
    logic             term;
    logic             load;
    logic             rd_done;
    logic             pick_hi;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] new_val;
    logic [CNT_W-1:0] src;

    always_comb begin
        s_d       = s_q;
        s_d.gate_q = gate;
        load      = 1'b0;
        new_val   = '0;
        rd_done   = 1'b0;

        // Square wave: an odd count takes 1 (high phase) or 3 (low phase) first
        if (!s_q.sq)        step = 2'd1;
        else if (s_q.cnt[0]) step = s_q.out ? 2'd1 : 2'd3;
        else                step = 2'd2;
        nxt  = sub_small(s_q.cnt, step, s_q.bcd);
        term = (s_q.cnt != '0) && (s_q.cnt <= CNT_W'(step));

        // R4: gate low forces high, gate rise restarts, tick advances
        if (s_q.armed) begin
            if (!gate) begin
                s_d.out = 1'b1;
            end else if (!s_q.gate_q) begin
                s_d.cnt = s_q.reload;
            end else if (tick) begin
                if (term) begin
                    s_d.cnt = s_q.reload;
                    s_d.out = s_q.sq ? !s_q.out : 1'b0;
                end else begin
                    s_d.cnt = nxt;
                    if (!s_q.sq) s_d.out = 1'b1;
                end
            end
        end

        // Readback: snapshot when held, live count otherwise (R9, R10)
        src     = s_q.held ? s_q.snap : s_q.cnt;
        pick_hi = (s_q.acc == ACC_HI) || (s_q.acc == ACC_LOHI && s_q.rd_hi);
        rdata   = pick_hi ? src[CNT_W-1 -: BUS_W] : src[BUS_W-1:0];
        if (data_rd) begin
            rd_done = (s_q.acc != ACC_LOHI) || s_q.rd_hi;
            if (s_q.acc == ACC_LOHI) s_d.rd_hi = !s_q.rd_hi;
            if (rd_done) s_d.held = 1'b0;
        end

        if (latch_cmd && !s_q.held) begin
            s_d.snap = s_q.cnt;
            s_d.held = 1'b1;
        end

        // R3: count load in the programmed byte format
        if (data_wr) begin
            case (s_q.acc)
                ACC_LO: begin
                    new_val[BUS_W-1:0] = wdata;
                    load = 1'b1;
                end
                ACC_HI: begin
                    new_val[CNT_W-1 -: BUS_W] = wdata;
                    load = 1'b1;
                end
                ACC_LOHI: begin
                    if (!s_q.wr_hi) begin
                        s_d.lo_hold = wdata;
                        s_d.wr_hi   = 1'b1;
                    end else begin
                        new_val[BUS_W-1:0]        = s_q.lo_hold;
                        new_val[CNT_W-1 -: BUS_W] = wdata;
                        s_d.wr_hi = 1'b0;
                        load      = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (load) begin
            s_d.reload = new_val;
            s_d.cnt    = new_val;
            s_d.armed  = 1'b1;
            s_d.out    = 1'b1;
        end

        // R11: new configuration halts the counter
        if (cfg_wr) begin
            s_d.acc   = cfg_acc;
            s_d.sq    = cfg_sq;
            s_d.bcd   = cfg_bcd;
            s_d.armed = 1'b0;
            s_d.out   = 1'b1;
            s_d.held  = 1'b0;
            s_d.wr_hi = 1'b0;
            s_d.rd_hi = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.acc    <= ACC_LOHI;
            s_q.out    <= 1'b1;
            s_q.gate_q <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tout = s_q.out;
endmodule

// File: rtl/tmr3_top.sv
module tmr3_top
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int BUS_W  = 8,
    parameter int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [NUM_CH-1:0] tick,
    input  logic [NUM_CH-1:0] gate,
    output logic [NUM_CH-1:0] tmr_out
);
    logic [NUM_CH-1:0] cfg_wr, latch_cmd, data_wr, data_rd;
    acc_e              cfg_acc;
    logic              cfg_sq, cfg_bcd;
    logic [BUS_W-1:0]  ch_rd [NUM_CH];

    tmr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_decode (
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .cfg_wr    (cfg_wr),
        .latch_cmd (latch_cmd),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .cfg_acc   (cfg_acc),
        .cfg_sq    (cfg_sq),
        .cfg_bcd   (cfg_bcd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick[g]),
            .gate      (gate[g]),
            .cfg_wr    (cfg_wr[g]),
            .cfg_acc   (cfg_acc),
            .cfg_sq    (cfg_sq),
            .cfg_bcd   (cfg_bcd),
            .latch_cmd (latch_cmd[g]),
            .data_wr   (data_wr[g]),
            .data_rd   (data_rd[g]),
            .wdata     (wdata),
            .rdata     (ch_rd[g]),
            .tout      (tmr_out[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_en && addr == ADDR_W'(i)) rdata = ch_rd[i];
        end
    end
endmodule

// File: rtl/tmr3_checks.sv
module tmr3_checks #(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2,
    parameter int BUS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  wdata,
    input logic [BUS_W-1:0]  rdata,
    input logic [NUM_CH-1:0] tick,
    input logic [NUM_CH-1:0] gate,
    input logic [NUM_CH-1:0] tmr_out
);
    p_ctrl_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(NUM_CH)) |-> (rdata == '0))
        else $error("control address read not zero");

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_gate_low_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !gate[i] |=> tmr_out[i])
            else $error("output not high while gate low, ch %0d", i);

        p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick[i] && !wr_en && gate[i]) |=> (tmr_out[i] == $past(tmr_out[i])))
            else $error("output moved without a tick, ch %0d", i);

        p_cfg_out_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(NUM_CH) && wdata[7:6] == 2'(i) && wdata[5:4] != 2'b00)
            |=> tmr_out[i])
            else $error("output not high after control word, ch %0d", i);
    end
endmodule

bind tmr3_top tmr3_checks #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_tmr3_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .tick    (tick),
    .gate    (gate),
    .tmr_out (tmr_out)
);

// File: tb/test_tmr3_top.sv
`timescale 1ns/1ps
module test_tmr3_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] tick = '0;
    logic [2:0] gate = 3'b111;
    logic [2:0] tmr_out;

    int ntests = 0;
    int nfail  = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;

    tmr3_top i_tmr3_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate), .tmr_out(tmr_out)
    );

    always #4 clk = ~clk;

    // Monitor: pops expected read bytes as the design returns them
    always @(posedge clk) begin
        if (rd_en) begin
            ntests++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL scoreboard: unexpected read, rdata=%h expected none", rdata);
            end else begin
                cur = exp_q.pop_front();
                if (rdata !== cur.val) begin
                    nfail++;
                    $display("FAIL %s: rdata=%h expected %h", cur.tag, rdata, cur.val);
                end
            end
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        it.val = e; it.tag = tag;
        exp_q.push_back(it);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] m);
        @(negedge clk);
        tick = m;
        @(negedge clk);
        tick = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
        ntests++;
        if (act !== e) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, e);
        end
    endtask

    task automatic run_rate(input int ch, input int n, input int cnt, input string tag);
        for (int k = 1; k <= cnt; k++) begin
            pulse(3'(1 << ch));
            chk(tag, 32'(tmr_out[ch]), (k % n == 0) ? 32'd0 : 32'd1);
        end
    endtask

    task automatic run_sq(input int ch, input int n, input string tag);
        int h, l, rem;
        logic o;
        h = (n + 1) / 2; l = n / 2; o = 1'b1; rem = h;
        for (int k = 1; k <= 2 * n + 1; k++) begin
            pulse(3'(1 << ch));
            rem--;
            if (rem == 0) begin
                o = !o;
                rem = o ? h : l;
            end
            chk(tag, 32'(tmr_out[ch]), 32'(o));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 outputs high", 32'(tmr_out), 32'h7);
        bus_rd(2'd0, 8'h00, "R1 ch0 lsb");
        bus_rd(2'd0, 8'h00, "R1 ch0 msb");

        // R5/R3: ch0 binary rate generator, N=5, LSB then MSB
        bus_wr(2'd3, 8'h34);
        bus_wr(2'd0, 8'h05);
        bus_wr(2'd0, 8'h00);
        run_rate(0, 5, 11, "R5 rate N5");

        // R7: ch1 square even N=6 ; R8: odd N=5
        bus_wr(2'd3, 8'h76);
        bus_wr(2'd1, 8'h06);
        bus_wr(2'd1, 8'h00);
        run_sq(1, 6, "R7 square N6");
        bus_wr(2'd3, 8'h76);
        bus_wr(2'd1, 8'h05);
        bus_wr(2'd1, 8'h00);
        run_sq(1, 5, "R8 square N5");
        bus_wr(2'd3, 8'h76);
        bus_wr(2'd1, 8'h03);
        bus_wr(2'd1, 8'h00);
        run_sq(1, 3, "R8 square N3");

        // R6: ch2 BCD, load 0 -> 9999 after one tick
        bus_wr(2'd3, 8'hB5);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd2, 8'h00);
        pulse(3'b100);
        bus_rd(2'd2, 8'h99, "R6 bcd wrap lsb");
        bus_rd(2'd2, 8'h99, "R6 bcd wrap msb");
        repeat (3) pulse(3'b100);
        bus_rd(2'd2, 8'h96, "R6 bcd lsb");
        bus_rd(2'd2, 8'h99, "R6 bcd msb");
        bus_wr(2'd2, 8'h12);
        bus_wr(2'd2, 8'h00);
        repeat (3) pulse(3'b100);
        bus_rd(2'd2, 8'h09, "R6 bcd borrow lsb");
        bus_rd(2'd2, 8'h00, "R6 bcd borrow msb");

        // R3: LSB-only and MSB-only formats
        bus_wr(2'd3, 8'h14);
        bus_wr(2'd0, 8'h07);
        repeat (2) pulse(3'b001);
        bus_rd(2'd0, 8'h05, "R3 lsb only");
        bus_wr(2'd3, 8'h24);
        bus_wr(2'd0, 8'h02);
        pulse(3'b001);
        bus_rd(2'd0, 8'h01, "R3 msb only");

        // R9/R10: latch on the fly
        bus_wr(2'd3, 8'h34);
        bus_wr(2'd0, 8'h34);
        bus_wr(2'd0, 8'h12);
        repeat (4) pulse(3'b001);
        bus_wr(2'd3, 8'h00);
        repeat (3) pulse(3'b001);
        bus_wr(2'd3, 8'h00);
        bus_rd(2'd0, 8'h30, "R9 latched lsb");
        repeat (2) pulse(3'b001);
        bus_rd(2'd0, 8'h12, "R9 latched msb");
        bus_rd(2'd0, 8'h2B, "R10 live lsb");
        bus_rd(2'd0, 8'h12, "R10 live msb");
        bus_wr(2'd3, 8'h00);
        pulse(3'b001);
        bus_rd(2'd0, 8'h2B, "R9 relatch lsb");
        bus_rd(2'd0, 8'h12, "R9 relatch msb");

        // R11: new control word halts ch0 at 0x122A
        bus_wr(2'd3, 8'h34);
        chk("R11 out high after cfg", 32'(tmr_out[0]), 32'd1);
        repeat (5) pulse(3'b001);
        chk("R11 out stays high", 32'(tmr_out[0]), 32'd1);
        bus_rd(2'd0, 8'h2A, "R11 halted lsb");
        bus_rd(2'd0, 8'h12, "R11 halted msb");
        bus_wr(2'd0, 8'h03);
        pulse(3'b001);
        bus_rd(2'd0, 8'h2A, "R3 no count before msb lsb");
        bus_rd(2'd0, 8'h12, "R3 no count before msb msb");
        bus_wr(2'd0, 8'h00);
        // R2: selector 3 ignored, ch0 keeps rate mode with N=3
        bus_wr(2'd3, 8'hF4);
        bus_rd(2'd3, 8'h00, "R2 ctrl read zero");
        run_rate(0, 3, 4, "R2 sel3 ignored");
        // R12: ch0 ticks left ch2 at 0009
        bus_rd(2'd2, 8'h09, "R12 ch2 lsb");
        bus_rd(2'd2, 8'h00, "R12 ch2 msb");

        // R4: gate behaviour on ch1
        bus_wr(2'd3, 8'h74);
        gate[1] = 1'b0;
        bus_wr(2'd1, 8'h04);
        bus_wr(2'd1, 8'h00);
        repeat (5) pulse(3'b010);
        chk("R4 gate low out", 32'(tmr_out[1]), 32'd1);
        bus_rd(2'd1, 8'h04, "R4 gated lsb");
        bus_rd(2'd1, 8'h00, "R4 gated msb");
        @(negedge clk); gate[1] = 1'b1;
        @(negedge clk);
        repeat (4) pulse(3'b010);
        chk("R4 terminal low", 32'(tmr_out[1]), 32'd0);
        gate[1] = 1'b0;
        @(negedge clk);
        chk("R4 gate forces high", 32'(tmr_out[1]), 32'd1);
        gate[1] = 1'b1;
        @(negedge clk);
        pulse(3'b010);
        bus_rd(2'd1, 8'h03, "R4 reload on rise lsb");
        bus_rd(2'd1, 8'h00, "R4 reload on rise msb");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            nfail++;
            $display("FAIL scoreboard: %0d reads pending, expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule